// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block takes four level-sensitive shared PCI interrupt lines and steers each one onto one of sixteen legacy interrupt-controller request lines. Each shared line has its own byte-wide steering register. A value below the line count selects the target output. Any larger value disables that shared line. When several enabled shared lines point at the same output, that output is the OR of their levels. The registers are written through a byte-addressed configuration write port, where a byte enable qualifies each lane of a 32-bit word. They are read back through a matching read port.

The block also carries three small combinational helpers. A slot swizzle turns a device's interrupt pin and slot number into a shared-line index. A route query reports whether a shared line is enabled and, if it is, which output it drives. A write-notification port reports each steering byte just written, in a reduced four-bit form, one clock after the write.

The level map holds one bit for each pair of output line and shared line. It is rebuilt on every clock from the current input levels and the steering values that take effect on that edge. A change in an input or in a steering byte therefore shows up on the outputs exactly one clock later.

Top module: `pirq_router`

## Requirements
- R1: After reset all four steering bytes read 0x80, all outputs are low and the route query reports every shared line disabled.
- R2: A shared line whose steering byte is below 16 drives output line number equal to that byte when high; a steering byte of 16 or more (including 0x10 and 0x80) makes it drive nothing.
- R3: Each output is high exactly when at least one enabled shared line steered to it is high (wired-OR).
- R4: An input level change appears on the outputs one clock edge later and not before.
- R5: Steering bytes live at byte addresses 0x60 (line A) to 0x63 (line D); write-port byte lane i addresses byte {addr[7:2], i}; only lanes whose enable is set and whose address falls in 0x60–0x63 update a register, and a write with the write strobe low changes nothing.
- R6: A steering write re-evaluates all outputs one clock later from the current input levels, with no input change needed.
- R7: The route query for a shared line returns enable=1 and the line number when its steering byte is below 16, otherwise enable=0 and line 0.
- R8: The swizzle maps pin P (INTA=0..INTD=3) in slot S to shared-line index (P + S − 1) mod 4.
- R9: One clock after a write, note_vld bit k is set for each steering byte k written, and note_code[4k+3:4k] holds 0 if that byte's bit 7 is set, else its low four bits; with no write, note_vld is 0.
- R10: A read at any byte address of the 0x60 word returns line A's byte in bits 7:0 through line D's byte in bits 31:24; reads of other words return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pirq_in | input | 4 | Shared interrupt line levels, synchronous to clk |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 8 | Write byte address (low two bits ignored) |
| cfg_wr_be | input | 4 | Write byte-lane enables |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_addr | input | 8 | Read byte address (low two bits ignored) |
| cfg_rd_data | output | 32 | Read data, combinational |
| qry_pirq | input | 2 | Shared line selected for route query |
| qry_en | output | 1 | Selected line is enabled |
| qry_line | output | 4 | Target output line of the selected line |
| swz_slot | input | 5 | Device slot number |
| swz_pin | input | 2 | Device interrupt pin |
| swz_pirq | output | 2 | Swizzled shared-line index |
| note_vld | output | 4 | Per-line flag: steering byte written on last edge |
| note_code | output | 16 | Reduced four-bit steering code per line |
| irq_out | output | 16 | Interrupt-controller request lines |

## Verification
Every one of the sixteen input patterns is applied under four steering layouts. In the first, all lines go to distinct outputs, which shows that each line reaches its own target. In the second, all four share one output, which isolates the OR. A mixed layout with disabled values 0x10 and 0x80 and two lines sharing an output separates disable from routing. A last layout adds an 0xFF byte and a shared line 0. A sweep of one steering byte through 0 to 31 locates the 15/16 boundary. Partial byte-enable writes, a write with an unaligned address and a write to a neighbouring word show which lanes take effect. The swizzle is checked exhaustively over all slots and pins. Latency is checked by sampling just before and just after the edge that follows a change.

// File: rtl/pirq_router.sv
module pirq_router #(
  parameter int NUM_PIRQ   = 4,
  parameter int NUM_LINES  = 16,
  parameter int ADDR_W     = 8,
  parameter int STEER_BASE = 'h60,
  parameter logic [7:0] STEER_RST = 8'h80
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_PIRQ-1:0]     pirq_in,
  input  logic                    cfg_wr_en,
  input  logic [ADDR_W-1:0]       cfg_wr_addr,
  input  logic [3:0]              cfg_wr_be,
  input  logic [31:0]             cfg_wr_data,
  input  logic [ADDR_W-1:0]       cfg_rd_addr,
  output logic [31:0]             cfg_rd_data,
  input  logic [$clog2(NUM_PIRQ)-1:0]  qry_pirq,
  output logic                    qry_en,
  output logic [$clog2(NUM_LINES)-1:0] qry_line,
  input  logic [4:0]              swz_slot,
  input  logic [1:0]              swz_pin,
  output logic [$clog2(NUM_PIRQ)-1:0]  swz_pirq,
  output logic [NUM_PIRQ-1:0]     note_vld,
  output logic [NUM_PIRQ*4-1:0]   note_code,
  output logic [NUM_LINES-1:0]    irq_out
);
  localparam int PIRQ_W = $clog2(NUM_PIRQ);
  localparam int LINE_W = $clog2(NUM_LINES);
  localparam logic [7:0] LINES8 = 8'(NUM_LINES);

  logic [7:0]          steer_q [NUM_PIRQ];
  logic [7:0]          steer_d [NUM_PIRQ];
  logic [NUM_PIRQ-1:0] wr_hit;
  logic [NUM_PIRQ-1:0] lvl_q [NUM_LINES];

  always_comb begin
    wr_hit = '0;
    for (int k = 0; k < NUM_PIRQ; k++) begin
      steer_d[k] = steer_q[k];
      for (int l = 0; l < 4; l++) begin
        if (cfg_wr_en && cfg_wr_be[l] &&
            {cfg_wr_addr[ADDR_W-1:2], 2'(l)} == ADDR_W'(STEER_BASE + k)) begin
          steer_d[k] = cfg_wr_data[8*l +: 8];
          wr_hit[k]  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_PIRQ; k++) steer_q[k] <= STEER_RST;
      for (int j = 0; j < NUM_LINES; j++) lvl_q[j] <= '0;
      note_vld  <= '0;
      note_code <= '0;
    end else begin
      for (int k = 0; k < NUM_PIRQ; k++) begin
        steer_q[k]        <= steer_d[k];
        note_code[4*k +: 4] <= steer_d[k][7] ? 4'h0 : steer_d[k][3:0];
      end
      note_vld <= wr_hit;
      for (int j = 0; j < NUM_LINES; j++)
        for (int k = 0; k < NUM_PIRQ; k++)
          lvl_q[j][k] <= pirq_in[k] && (steer_d[k] < LINES8) &&
                         (steer_d[k][LINE_W-1:0] == LINE_W'(j));
    end
  end

  for (genvar j = 0; j < NUM_LINES; j++) begin : g_line
    assign irq_out[j] = |lvl_q[j];
  end

  always_comb begin
    cfg_rd_data = '0;
    for (int l = 0; l < 4; l++)
      for (int k = 0; k < NUM_PIRQ; k++)
        if ({cfg_rd_addr[ADDR_W-1:2], 2'(l)} == ADDR_W'(STEER_BASE + k))
          cfg_rd_data[8*l +: 8] = steer_q[k];
  end

  logic [7:0] qry_sel;
  assign qry_sel  = steer_q[qry_pirq];
  assign qry_en   = qry_sel < LINES8;
  assign qry_line = qry_en ? qry_sel[LINE_W-1:0] : '0;

  logic [7:0] swz_sum;
  assign swz_sum  = 8'(swz_pin) + 8'(swz_slot) + 8'(NUM_PIRQ - 1);
  assign swz_pirq = PIRQ_W'(swz_sum % 8'(NUM_PIRQ));
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
  parameter int NUM_PIRQ  = 4,
  parameter int NUM_LINES = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_PIRQ-1:0]           pirq_in,
  input logic                          cfg_wr_en,
  input logic                          qry_en,
  input logic [$clog2(NUM_LINES)-1:0]  qry_line,
  input logic [4:0]                    swz_slot,
  input logic [1:0]                    swz_pin,
  input logic [$clog2(NUM_PIRQ)-1:0]   swz_pirq,
  input logic [NUM_PIRQ-1:0]           note_vld,
  input logic [NUM_LINES-1:0]          irq_out
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> irq_out == '0);

  a_r4_no_input_no_output: assert property (@(posedge clk) disable iff (!rst_n)
    pirq_in == '0 |=> irq_out == '0);

  a_r3_lines_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_out) <= NUM_PIRQ);

  a_r7_disabled_line_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !qry_en |-> qry_line == '0);

  a_r8_slot_one_identity: assert property (@(posedge clk) disable iff (!rst_n)
    swz_slot == 5'd1 |-> swz_pirq == swz_pin);

  a_r9_no_write_no_note: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr_en |=> note_vld == '0);
endmodule

bind pirq_router pirq_router_chk #(.NUM_PIRQ(NUM_PIRQ), .NUM_LINES(NUM_LINES)) u_chk (.*);

// File: tb/pirq_router_bench.sv
`timescale 1ns/1ps
module pirq_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  pirq_in = '0;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_wr_addr = '0;
  logic [3:0]  cfg_wr_be = '0;
  logic [31:0] cfg_wr_data = '0;
  logic [7:0]  cfg_rd_addr = 8'h60;
  logic [31:0] cfg_rd_data;
  logic [1:0]  qry_pirq = '0;
  logic        qry_en;
  logic [3:0]  qry_line;
  logic [4:0]  swz_slot = '0;
  logic [1:0]  swz_pin = '0;
  logic [1:0]  swz_pirq;
  logic [3:0]  note_vld;
  logic [15:0] note_code;
  logic [15:0] irq_out;

  int total = 0;
  int bad = 0;
  logic [7:0] es [4];

  always #2.5 clk = ~clk;

  pirq_router u_pirq_router (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_irq(input logic [3:0] p);
    logic [15:0] r = '0;
    for (int k = 0; k < 4; k++)
      if (p[k] && es[k] < 8'd16) r[es[k][3:0]] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] exp_word();
    return {es[3], es[2], es[1], es[0]};
  endfunction

  function automatic logic [3:0] code_of(input logic [7:0] b);
    return b[7] ? 4'h0 : b[3:0];
  endfunction

  logic [3:0]  exp_nv;
  logic [15:0] exp_nc;

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_be = be; cfg_wr_data = d;
    exp_nv = '0;
    for (int k = 0; k < 4; k++)
      for (int l = 0; l < 4; l++)
        if (be[l] && {a[7:2], 2'(l)} == 8'(8'h60 + k)) begin
          es[k] = d[8*l +: 8];
          exp_nv[k] = 1'b1;
        end
    for (int k = 0; k < 4; k++) exp_nc[4*k +: 4] = code_of(es[k]);
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic setp(input logic [3:0] p);
    @(negedge clk);
    pirq_in = p;
    @(negedge clk);
  endtask

  task automatic check_query(input string req);
    for (int k = 0; k < 4; k++) begin
      qry_pirq = 2'(k);
      #0.1;
      chk(req, {31'd0, qry_en}, {31'd0, es[k] < 8'd16});
      chk(req, {28'd0, qry_line}, (es[k] < 8'd16) ? {28'd0, es[k][3:0]} : 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] layouts [4];
    layouts[0] = 32'h0F0A0503;
    layouts[1] = 32'h09090909;
    layouts[2] = 32'h07071080;
    layouts[3] = 32'h0000FF0E;
    for (int k = 0; k < 4; k++) es[k] = 8'h80;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    cfg_rd_addr = 8'h60; #0.1;
    chk("R1 reset steering", cfg_rd_data, 32'h80808080);
    chk("R1 reset outputs", {16'd0, irq_out}, 32'd0);
    check_query("R1 reset query");
    // R10 readback decoding
    cfg_rd_addr = 8'h63; #0.1;
    chk("R10 unaligned read", cfg_rd_data, 32'h80808080);
    cfg_rd_addr = 8'h64; #0.1;
    chk("R10 other word", cfg_rd_data, 32'd0);
    cfg_rd_addr = 8'h5C; #0.1;
    chk("R10 other word", cfg_rd_data, 32'd0);
    cfg_rd_addr = 8'h60;

    // R2/R3 sweep all input patterns under several layouts
    for (int c = 0; c < 4; c++) begin
      wr(8'h60, 4'hF, layouts[c]);
      chk("R9 note valid", {28'd0, note_vld}, {28'd0, exp_nv});
      chk("R9 note code", {16'd0, note_code}, {16'd0, exp_nc});
      chk("R10 readback", cfg_rd_data, exp_word());
      check_query("R7 route query");
      for (int p = 0; p < 16; p++) begin
        setp(4'(p));
        chk((c == 1) ? "R3 wired-OR" : "R2 routing", {16'd0, irq_out}, {16'd0, exp_irq(4'(p))});
      end
    end

    // R4 latency: unchanged before the edge, updated after
    wr(8'h60, 4'hF, 32'h0F0A0503);
    setp(4'h0);
    @(negedge clk);
    pirq_in = 4'hA;
    #1;
    chk("R4 before edge", {16'd0, irq_out}, 32'd0);
    @(negedge clk);
    chk("R4 after edge", {16'd0, irq_out}, {16'd0, exp_irq(4'hA)});

    // R6 steering change with inputs held
    setp(4'hF);
    wr(8'h60, 4'b0010, 32'h00000C00);
    chk("R6 reroute", {16'd0, irq_out}, {16'd0, exp_irq(4'hF)});
    wr(8'h60, 4'b1000, 32'h80000000);
    chk("R6 disable", {16'd0, irq_out}, {16'd0, exp_irq(4'hF)});

    // R5 byte enables, unaligned address, other word, strobe low
    wr(8'h62, 4'b0101, 32'h11223344);
    chk("R5 partial lanes", cfg_rd_data, exp_word());
    chk("R5 partial note", {28'd0, note_vld}, {28'd0, exp_nv});
    chk("R5 partial output", {16'd0, irq_out}, {16'd0, exp_irq(4'hF)});
    wr(8'h64, 4'hF, 32'h01010101);
    chk("R5 other word", cfg_rd_data, exp_word());
    chk("R5 other word note", {28'd0, note_vld}, 32'd0);
    @(negedge clk);
    cfg_wr_addr = 8'h60; cfg_wr_be = 4'hF; cfg_wr_data = 32'h01010101; cfg_wr_en = 1'b0;
    @(negedge clk);
    chk("R5 strobe low", cfg_rd_data, exp_word());

    // R9 reduced codes and clearing
    wr(8'h60, 4'hF, 32'h8F0F9305);
    chk("R9 codes", {16'd0, note_code}, 32'h00000F05);
    chk("R9 valid", {28'd0, note_vld}, 32'h0000000F);
    @(negedge clk);
    chk("R9 clears", {28'd0, note_vld}, 32'd0);

    // R2 boundary sweep of line A's steering byte
    setp(4'h1);
    for (int v = 0; v < 32; v++) begin
      wr(8'h60, 4'b0001, 32'(v));
      chk("R2 value sweep", {16'd0, irq_out}, (v < 16) ? (32'd1 << v) : 32'd0);
      chk("R9 sweep code", {28'd0, note_code[3:0]}, {28'd0, code_of(8'(v))});
    end
    check_query("R7 after sweep");

    // R8 swizzle exhaustive
    for (int s = 0; s < 32; s++)
      for (int p = 0; p < 4; p++) begin
        swz_slot = 5'(s); swz_pin = 2'(p);
        #0.1;
        chk("R8 swizzle", {30'd0, swz_pirq}, 32'((p + s + 3) % 4));
      end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule